// File: doc/BRIEF.md
# Programmable LCD Timing Generator

This block produces the raster timing for a parallel RGB TFT panel. It runs entirely in the pixel clock domain. It drives horizontal sync, vertical sync and data enable. It also reports the column and row of the active pixel being shown, so that a downstream fetch unit can request the right pixel. Every horizontal and vertical segment can be programmed: the sync pulse, the back porch, the visible span and the front porch. The asserted level of each control output can also be programmed.

Configuration goes through a simple write port into a shadow set of registers. The raster never uses these shadow values directly. They reach the working set only through a reload request. An immediate request copies them on the next clock and restarts the raster. A blanking request waits for the last pixel of the current frame. Two sticky event flags, one for a programmed line and one for a completed reload, feed a single interrupt output through per-flag enables.

Top module: `lcd_raster_timer`

## Requirements
- R1: One line lasts hsw+hbp+hact+hfp clocks (fields at write addresses 0,1,2,3), and horizontal sync is asserted during the first hsw clocks of each line.
- R2: One frame lasts vsw+vbp+vact+vfp lines (addresses 4,5,6,7), and vertical sync is asserted during the first vsw lines of each frame.
- R3: Data enable is asserted only when the column lies in [hsw+hbp, hsw+hbp+hact) and the row lies in [vsw+vbp, vsw+vbp+vact). While data enable is asserted, pix_x and pix_y give the offsets inside that area. Otherwise both are zero.
- R4: The polarity word at address 8 has four bits: bit0 for horizontal sync, bit1 for vertical sync, bit2 for data enable, and bit3 for the clock edge select, which is driven out on lcd_pclk_inv. A bit value of 1 means the signal is active high. An inactive signal drives the inverse of its bit.
- R5: Writes to addresses 0..9 (address 9 holds the line-match number) change only the shadow set and have no effect on any output until a reload.
- R6: Writing 1 to bit0 at address 11 requests an immediate reload. On the next clock the shadow set is copied, both counters restart at zero, the reload flag is set, and reload_pend[0] clears.
- R7: Writing 1 to bit1 at address 11 requests a blanking reload. reload_pend[1] stays set until the clock that ends the last pixel of the frame, or any clock while disabled. At that clock the copy is made and the reload flag is set.
- R8: The line flag is set one clock after the raster sits at column 0 of the row given by the line-match number. Rows are counted from the start of vertical sync.
- R9: Both flags stay set until a write to address 13 clears them: bit0 clears the line flag and bit1 clears the reload flag. A set in the same clock as a clear wins. irq is the OR of each flag ANDed with its enable at address 12 (bit0 for line, bit1 for reload).
- R10: Address 10 bit0 enables the raster. While it is clear, both counters are held at zero, all three control outputs sit at their inactive level, and pix_x and pix_y are zero. Reset leaves the block disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | AW | Configuration write address |
| cfg_wdata | input | FW | Configuration write data |
| lcd_hsync | output | 1 | Horizontal sync, programmed polarity |
| lcd_vsync | output | 1 | Vertical sync, programmed polarity |
| lcd_de | output | 1 | Data enable, programmed polarity |
| lcd_pclk_inv | output | 1 | Clock edge select for the panel clock |
| pix_x | output | FW | Column inside the active area |
| pix_y | output | FW | Row inside the active area |
| irq | output | 1 | Enabled-flag interrupt |
| line_flag | output | 1 | Sticky line-match flag |
| reload_flag | output | 1 | Sticky reload-done flag |
| reload_pend | output | 2 | Pending reload requests {blanking, immediate} |

## Verification
A counter that wraps at the wrong count moves the sync edge or the data-enable edge within one line. A reference raster running beside the design therefore sees the error in the very next column where the edge should fall. A working set that is copied at the wrong moment shows up as a changed line length or polarity. This happens within a clock of an immediate request, or within one frame of a blanking request. A missed or early flag shows on line_flag, reload_flag and irq in the following clock. Random reconfiguration with small porches keeps frames short, so every wrap, copy and line match is compared many times.

// File: rtl/lcd_raster_pkg.sv
package lcd_raster_pkg;
  localparam int FW = 12;          // field width, fits 800x600 with margins
  localparam int TW = FW + 2;      // counter width, holds a sum of four fields

  localparam int A_HSW  = 0;
  localparam int A_HBP  = 1;
  localparam int A_HACT = 2;
  localparam int A_HFP  = 3;
  localparam int A_VSW  = 4;
  localparam int A_VBP  = 5;
  localparam int A_VACT = 6;
  localparam int A_VFP  = 7;
  localparam int A_POL  = 8;
  localparam int A_LINE = 9;
  localparam int A_CTRL = 10;
  localparam int A_RLD  = 11;
  localparam int A_IEN  = 12;
  localparam int A_CLR  = 13;

  typedef struct packed {
    logic [FW-1:0] hsw, hbp, hact, hfp;
    logic [FW-1:0] vsw, vbp, vact, vfp;
    logic [FW-1:0] line;
    logic [3:0]    pol;
  } lcd_timing_t;

  localparam lcd_timing_t TIMING_RST = '{
    hsw: FW'(2), hbp: FW'(2), hact: FW'(8), hfp: FW'(2),
    vsw: FW'(1), vbp: FW'(1), vact: FW'(4), vfp: FW'(1),
    line: '0, pol: 4'b0000};

  function automatic logic [TW-1:0] widen(input logic [FW-1:0] f);
    return {2'b00, f};
  endfunction

  function automatic logic [TW-1:0] span_total(input logic [FW-1:0] a, b, c, d);
    return widen(a) + widen(b) + widen(c) + widen(d);
  endfunction

  function automatic logic in_span(input logic [TW-1:0] pos, start,
                                   input logic [FW-1:0] len);
    return (pos >= start) && (pos < start + widen(len));
  endfunction

  function automatic logic [FW-1:0] offset_in(input logic [TW-1:0] pos, start);
    logic [TW-1:0] d;
    d = pos - start;
    return d[FW-1:0];
  endfunction

  function automatic logic drive_level(input logic active, input logic high_true);
    return active ? high_true : !high_true;
  endfunction
endpackage

// File: rtl/lcd_axis.sv
module lcd_axis
  import lcd_raster_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          restart,
  input  logic          step,
  input  logic [FW-1:0] sw,
  input  logic [FW-1:0] bp,
  input  logic [FW-1:0] ac,
  input  logic [FW-1:0] fp,
  output logic [TW-1:0] pos,
  output logic [FW-1:0] off,
  output logic          last,
  output logic          in_sync,
  output logic          in_act
);
  localparam logic [TW-1:0] ONE = TW'(1);

  logic [TW-1:0] total;
  logic [TW-1:0] act_start;

  assign total     = span_total(sw, bp, ac, fp);
  assign act_start = widen(sw) + widen(bp);
  assign last      = (pos == total - ONE);
  assign in_sync   = (pos < widen(sw));
  assign in_act    = in_span(pos, act_start, ac);
  assign off       = offset_in(pos, act_start);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pos <= '0;
    else if (!run || restart)  pos <= '0;
    else if (step)             pos <= last ? '0 : pos + ONE;
  end

  // R1 / R2: the position never leaves the programmed period
  a_r1_pos_in_period: assert property (@(posedge clk) disable iff (!rst_n)
    (run && total != '0) |-> (pos < total));
  // R10: an idle axis sits at zero
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!run) |=> (pos == '0));
endmodule

// File: rtl/lcd_cfg_bank.sv
module lcd_cfg_bank
  import lcd_raster_pkg::*;
#(
  parameter int AW = 4
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [FW-1:0] wdata,
  input  logic          frame_end,
  output lcd_timing_t   act,
  output logic          en,
  output logic [1:0]    ien,
  output logic [1:0]    clr,
  output logic          copy,
  output logic          imm_fire,
  output logic [1:0]    pend
);
  lcd_timing_t sh;
  logic req_imm, req_blk;
  logic imm_set, blk_set, blk_fire;

  assign imm_set  = we && (addr == AW'(A_RLD)) && wdata[0];
  assign blk_set  = we && (addr == AW'(A_RLD)) && wdata[1];
  assign imm_fire = req_imm;
  assign blk_fire = req_blk && (frame_end || !en);
  assign copy     = imm_fire || blk_fire;
  assign clr      = (we && addr == AW'(A_CLR)) ? wdata[1:0] : 2'b00;
  assign pend     = {req_blk, req_imm};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= TIMING_RST;
      act     <= TIMING_RST;
      en      <= 1'b0;
      ien     <= 2'b00;
      req_imm <= 1'b0;
      req_blk <= 1'b0;
    end else begin
      if (copy) act <= sh;
      req_imm <= imm_set;
      req_blk <= blk_set || (req_blk && !blk_fire);
      if (we) begin
        case (addr)
          AW'(A_HSW):  sh.hsw  <= wdata;
          AW'(A_HBP):  sh.hbp  <= wdata;
          AW'(A_HACT): sh.hact <= wdata;
          AW'(A_HFP):  sh.hfp  <= wdata;
          AW'(A_VSW):  sh.vsw  <= wdata;
          AW'(A_VBP):  sh.vbp  <= wdata;
          AW'(A_VACT): sh.vact <= wdata;
          AW'(A_VFP):  sh.vfp  <= wdata;
          AW'(A_POL):  sh.pol  <= wdata[3:0];
          AW'(A_LINE): sh.line <= wdata;
          AW'(A_CTRL): en      <= wdata[0];
          AW'(A_IEN):  ien     <= wdata[1:0];
          default: ;
        endcase
      end
    end
  end

  // R7: a blanking request waits while the frame is still running
  a_r7_blank_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (req_blk && en && !frame_end) |=> req_blk);
  // R5: the working set moves only on a copy
  a_r5_working_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!copy) |=> (act == $past(act)));
endmodule

// File: rtl/lcd_event_flags.sv
module lcd_event_flags #(
  parameter int N = 2
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] ien,
  output logic [N-1:0] flags,
  output logic         irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= set | (flags & ~clr);
  end

  assign irq = |(flags & ien);

  for (genvar gi = 0; gi < N; gi++) begin : g_chk
    // R9: sticky until cleared, set wins over clear
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[gi] && !clr[gi]) |=> flags[gi]);
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set[gi] |=> flags[gi]);
  end
endmodule

// File: rtl/lcd_raster_timer.sv
module lcd_raster_timer
  import lcd_raster_pkg::*;
#(
  parameter int AW = 4
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [FW-1:0] cfg_wdata,
  output logic          lcd_hsync,
  output logic          lcd_vsync,
  output logic          lcd_de,
  output logic          lcd_pclk_inv,
  output logic [FW-1:0] pix_x,
  output logic [FW-1:0] pix_y,
  output logic          irq,
  output logic          line_flag,
  output logic          reload_flag,
  output logic [1:0]    reload_pend
);
  lcd_timing_t act;
  logic        en, copy, imm_fire, frame_end, line_hit;
  logic [1:0]  ien, clr, flags;
  logic [TW-1:0] h_pos, v_pos;
  logic [FW-1:0] h_off, v_off;
  logic h_last, v_last, h_sync, v_sync, h_act, v_act;
  logic hs_on, vs_on, de_on;

  lcd_cfg_bank #(.AW(AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .frame_end(frame_end), .act(act), .en(en), .ien(ien), .clr(clr),
    .copy(copy), .imm_fire(imm_fire), .pend(reload_pend));

  lcd_axis u_h (
    .clk(clk), .rst_n(rst_n), .run(en), .restart(imm_fire), .step(1'b1),
    .sw(act.hsw), .bp(act.hbp), .ac(act.hact), .fp(act.hfp),
    .pos(h_pos), .off(h_off), .last(h_last), .in_sync(h_sync), .in_act(h_act));

  lcd_axis u_v (
    .clk(clk), .rst_n(rst_n), .run(en), .restart(imm_fire), .step(h_last),
    .sw(act.vsw), .bp(act.vbp), .ac(act.vact), .fp(act.vfp),
    .pos(v_pos), .off(v_off), .last(v_last), .in_sync(v_sync), .in_act(v_act));

  assign frame_end = en && h_last && v_last;
  assign line_hit  = en && (h_pos == '0) && (v_pos == widen(act.line));

  lcd_event_flags #(.N(2)) u_flags (
    .clk(clk), .rst_n(rst_n), .set({copy, line_hit}), .clr(clr), .ien(ien),
    .flags(flags), .irq(irq));

  assign line_flag   = flags[0];
  assign reload_flag = flags[1];

  assign hs_on = en && h_sync;
  assign vs_on = en && v_sync;
  assign de_on = en && h_act && v_act;

  assign lcd_hsync    = drive_level(hs_on, act.pol[0]);
  assign lcd_vsync    = drive_level(vs_on, act.pol[1]);
  assign lcd_de       = drive_level(de_on, act.pol[2]);
  assign lcd_pclk_inv = act.pol[3];
  assign pix_x        = de_on ? h_off : '0;
  assign pix_y        = de_on ? v_off : '0;

  // R3: coordinates reported while enabled stay inside the visible area
  a_r3_coords_inside: assert property (@(posedge clk) disable iff (!rst_n)
    de_on |-> (h_off < act.hact && v_off < act.vact));
  // R6: an immediate copy restarts the raster and raises the reload flag
  a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
    imm_fire |=> (h_pos == '0 && v_pos == '0));
  a_r6_flag: assert property (@(posedge clk) disable iff (!rst_n)
    imm_fire |=> reload_flag);
  // R8: the line match is recorded on the next clock
  a_r8_line_seen: assert property (@(posedge clk) disable iff (!rst_n)
    line_hit |=> line_flag);
endmodule

// File: tb/lcd_raster_timer_bench.sv
`timescale 1ns/1ps
module lcd_raster_timer_bench;
  localparam int AW = 4;
  localparam int FW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [FW-1:0] cfg_wdata = '0;
  logic lcd_hsync, lcd_vsync, lcd_de, lcd_pclk_inv, irq, line_flag, reload_flag;
  logic [FW-1:0] pix_x, pix_y;
  logic [1:0] reload_pend;

  always #2.5 clk = ~clk;

  lcd_raster_timer #(.AW(AW)) u_lcd_raster_timer (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .lcd_hsync(lcd_hsync), .lcd_vsync(lcd_vsync),
    .lcd_de(lcd_de), .lcd_pclk_inv(lcd_pclk_inv), .pix_x(pix_x), .pix_y(pix_y),
    .irq(irq), .line_flag(line_flag), .reload_flag(reload_flag),
    .reload_pend(reload_pend));

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  // reference state: 0 hsw 1 hbp 2 hact 3 hfp 4 vsw 5 vbp 6 vact 7 vfp 8 pol 9 line
  int msh[10];
  int mact[10];
  int mh, mv, men, mien, mfl, rimm, rblk;

  function automatic int htot_f(); return mact[0]+mact[1]+mact[2]+mact[3]; endfunction
  function automatic int vtot_f(); return mact[4]+mact[5]+mact[6]+mact[7]; endfunction
  function automatic int lvl(input bit on, input int bitpos);
    int p; p = (mact[8] >> bitpos) & 1;
    return on ? p : 1 - p;
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare();
    int hst, vst; bit ha, va, de;
    hst = mact[0] + mact[1];
    vst = mact[4] + mact[5];
    ha = (mh >= hst) && (mh < hst + mact[2]);
    va = (mv >= vst) && (mv < vst + mact[6]);
    de = men && ha && va;
    chk("R1 hsync", lcd_hsync, lvl(men && mh < mact[0], 0));
    chk("R2 vsync", lcd_vsync, lvl(men && mv < mact[4], 1));
    chk("R3 de", lcd_de, lvl(de, 2));
    chk("R3 pix_x", pix_x, de ? mh - hst : 0);
    chk("R3 pix_y", pix_y, de ? mv - vst : 0);
    chk("R4 pclk_inv", lcd_pclk_inv, (mact[8] >> 3) & 1);
    chk("R8 line_flag", line_flag, mfl & 1);
    chk("R6 reload_flag", reload_flag, (mfl >> 1) & 1);
    chk("R9 irq", irq, ((mfl & mien) != 0) ? 1 : 0);
    chk("R7 reload_pend", reload_pend, (rblk << 1) | rimm);
  endtask

  task automatic model_edge(input bit we, input int a, input int d);
    int ht, vt, clr, setv; bit fe, lh, immf, blkf, cp;
    ht = htot_f(); vt = vtot_f();
    fe = men && mh == ht - 1 && mv == vt - 1;
    lh = men && mh == 0 && mv == mact[9];
    immf = rimm; blkf = rblk && (fe || !men); cp = immf || blkf;
    clr = (we && a == 13) ? (d & 3) : 0;
    setv = (cp ? 2 : 0) | (lh ? 1 : 0);
    mfl = (mfl & ~clr) | setv;
    if (!men || immf) begin mh = 0; mv = 0; end
    else if (mh == ht - 1) begin mh = 0; mv = (mv == vt - 1) ? 0 : mv + 1; end
    else mh = mh + 1;
    if (cp) for (int i = 0; i < 10; i++) mact[i] = msh[i];
    rimm = (we && a == 11 && (d & 1)) ? 1 : 0;
    rblk = ((we && a == 11 && (d & 2)) || (rblk && !blkf)) ? 1 : 0;
    if (we) begin
      if (a == 8) msh[8] = d & 15;
      else if (a < 10) msh[a] = d & 12'hfff;
      else if (a == 10) men = d & 1;
      else if (a == 12) mien = d & 3;
    end
  endtask

  // one clock: drive, let the edge pass, update the reference, compare
  task automatic cyc(input bit we, input int a, input int d);
    cfg_we = we; cfg_addr = AW'(a); cfg_wdata = FW'(d);
    @(posedge clk); #1;
    model_edge(we, a, d);
    cfg_we = 1'b0;
    @(negedge clk);
    compare();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(150000 * 5);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    int cnt, seed, r, a, d;
    seed = $urandom(32'd5381);
    msh = '{2, 2, 8, 2, 1, 1, 4, 1, 0, 0};
    mact = msh;
    mh = 0; mv = 0; men = 0; mien = 0; mfl = 0; rimm = 0; rblk = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R10: reset state, disabled, all outputs inactive (low-true => high)
    chk("R10 reset hsync", lcd_hsync, 1);
    chk("R10 reset de", lcd_de, 1);
    compare();
    repeat (5) cyc(0, 0, 0);
    chk("R10 disabled pix_x", pix_x, 0);

    cyc(1, 10, 1);                 // enable
    cyc(1, 2, 3);                  // shadow hact=3, no reload yet
    cnt = 0;
    for (int i = 0; i < 98; i++) begin cyc(0, 0, 0); if (lcd_de == 1'b0) cnt++; end
    chk("R5 de count before reload", cnt, 32);

    cyc(1, 11, 1);                 // immediate request
    chk("R6 pend set", reload_pend, 1);
    cyc(0, 0, 0);
    chk("R6 pend self-clears", reload_pend, 0);
    chk("R6 flag set", reload_flag, 1);
    cnt = 0;
    for (int i = 0; i < 63; i++) begin cyc(0, 0, 0); if (lcd_de == 1'b0) cnt++; end
    chk("R6 de count after reload", cnt, 12);

    cyc(1, 2, 5);
    cyc(1, 8, 4'b0111);            // active-high sync and enable
    cyc(1, 11, 2);                 // blanking request
    for (int i = 0; i < 10; i++) cyc(0, 0, 0);
    chk("R7 still pending mid frame", reload_pend, 2);
    for (int i = 0; i < 63; i++) cyc(0, 0, 0);
    chk("R7 taken at frame end", reload_pend, 0);
    chk("R4 polarity applied", lcd_pclk_inv, 0);

    cyc(1, 13, 3);                 // clear both flags
    chk("R9 cleared", reload_flag, 0);
    cyc(1, 12, 3);

    for (int i = 0; i < 6000; i++) begin
      r = $urandom % 100;
      if (r < 4) begin
        a = $urandom % 10;
        if (a == 8) d = $urandom % 16;
        else if (a == 9) d = $urandom % 14;
        else if (a == 2 || a == 6) d = 1 + $urandom % 6;
        else d = 1 + $urandom % 4;
        cyc(1, a, d);
      end
      else if (r < 6)  cyc(1, 11, 1 + $urandom % 3);
      else if (r < 8)  cyc(1, 13, $urandom % 4);
      else if (r < 9)  cyc(1, 12, $urandom % 4);
      else if (r < 10) cyc(1, 10, ($urandom % 4 == 0) ? 0 : 1);
      else             cyc(0, 0, 0);
    end
    summary();
  end
endmodule